// File: doc/BRIEF.md
# Four-Point Inverse Cosine Transform Stage

This block takes four signed 16-bit transform coefficients and produces four signed 16-bit samples of a one-dimensional 4-point inverse DCT. It uses fixed-point cosine weights with 14 fractional bits. The same block serves the row pass and the column pass of a separable 2-D inverse transform. Transposing between the passes is left to the surrounding logic.

The datapath has four parts. An even butterfly scales the wrapped sum and the wrapped difference of the first and third coefficients by the cos(pi/4) weight. An odd rotation combines the second and fourth coefficients with the cos(pi/8) and cos(3pi/8) weights at 32-bit precision. Each of the four 32-bit terms is then rounded, shifted down by 14 and clamped to 16 bits. A final stage adds and subtracts the terms without saturation.

By default the outputs are registered, so the block has one cycle of latency, and a valid flag travels with the data. A parameter selects a purely combinational variant instead.

Top module: `idct4_stage`

## Requirements
- R1: The even terms are E0 = S*11585 and E1 = D*11585. S = c0+c2 and D = c0-c2 are each wrapped to 16-bit two's complement before the multiply.
- R2: The odd terms are O0 = c1*15137 + c3*6270 and O1 = c1*6270 - c3*15137, computed exactly at 32 bits.
- R3: Each 32-bit term T is reduced to floor((T + 8192) / 2^14), which rounds halves upward. A non-negative term never reduces to a negative value, and a negative term never reduces to a positive value.
- R4: Any reduced value above 32767 becomes 32767, and any reduced value below -32768 becomes -32768.
- R5: The output ordering is fixed. Using the reduced terms e0, e1, o0 and o1: y0 = e0+o0, y1 = e1+o1, y2 = e1-o1 and y3 = e0-o0.
- R6: The four output additions and subtractions wrap modulo 2^16 and never saturate.
- R7: In the registered variant, out_vld equals in_vld from the previous clock edge. Results appear on the edge after in_vld is sampled high.
- R8: In the registered variant, the outputs keep their value on any edge where in_vld is low.
- R9: While rst_n is low at a clock edge, out_vld and all four outputs are cleared to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Coefficients valid this cycle |
| in_c0 | input | 16 | Coefficient 0 (DC), signed |
| in_c1 | input | 16 | Coefficient 1, signed |
| in_c2 | input | 16 | Coefficient 2, signed |
| in_c3 | input | 16 | Coefficient 3, signed |
| out_vld | output | 1 | Results valid |
| out_y0 | output | 16 | Sample 0, signed |
| out_y1 | output | 16 | Sample 1, signed |
| out_y2 | output | 16 | Sample 2, signed |
| out_y3 | output | 16 | Sample 3, signed |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle valid latency;
- output holding while idle;
- the sign behaviour of each rounding narrower;
- the symmetries that must appear when the odd inputs are zero, or when the third coefficient is zero.

Bit-exactness cannot be shown this way: rounding, clamping, wrap in the input butterfly and in the final stage, and the output ordering. Those come only from the bench scenarios, which compare against an independent integer model and against hand-worked extreme cases with full-scale coefficients.

// File: rtl/idct4_pkg.sv
// Package: shared widths and Q14 cosine weights for the 4-point inverse DCT.
// Assumes: weights fit in 16 bits; products are formed at 32 bits.
package idct4_pkg;
    localparam int COEF_W  = 16;
    localparam int PROD_W  = 32;
    localparam int FRAC_W  = 14;
    localparam int W_COS16 = 11585;  // cos(pi/4)  * 2^14
    localparam int W_COS8  = 15137;  // cos(pi/8)  * 2^14
    localparam int W_COS24 = 6270;   // cos(3pi/8) * 2^14
endpackage

// File: rtl/idct4_even.sv
// Module: even butterfly. Wraps c0+c2 and c0-c2 to DW bits, then scales
// both by the cos(pi/4) weight into PW-bit products.
// Assumes: PW is wide enough for the product without overflow.
module idct4_even #(
    parameter int DW = idct4_pkg::COEF_W,
    parameter int PW = idct4_pkg::PROD_W
) (
    input  logic signed [DW-1:0] x0,
    input  logic signed [DW-1:0] x2,
    output logic signed [PW-1:0] e0,
    output logic signed [PW-1:0] e1
);
    localparam logic signed [PW-1:0] K16 = PW'(idct4_pkg::W_COS16);

    logic signed [DW-1:0] sum_w;
    logic signed [DW-1:0] dif_w;
    logic signed [PW-1:0] sum_x;
    logic signed [PW-1:0] dif_x;

    // wrapped butterfly at coefficient width, then sign-extend and scale
    always_comb begin
        sum_w = x0 + x2;
        dif_w = x0 - x2;
        sum_x = PW'(sum_w);
        dif_x = PW'(dif_w);
        e0    = sum_x * K16;
        e1    = dif_x * K16;
    end
endmodule

// File: rtl/idct4_odd.sv
// Module: odd rotation. Combines c1 and c3 with the cos(pi/8) and
// cos(3pi/8) weights, accumulating at PW bits.
// Assumes: PW holds the sum of two full-scale products.
module idct4_odd #(
    parameter int DW = idct4_pkg::COEF_W,
    parameter int PW = idct4_pkg::PROD_W
) (
    input  logic signed [DW-1:0] x1,
    input  logic signed [DW-1:0] x3,
    output logic signed [PW-1:0] o0,
    output logic signed [PW-1:0] o1
);
    localparam logic signed [PW-1:0] K8  = PW'(idct4_pkg::W_COS8);
    localparam logic signed [PW-1:0] K24 = PW'(idct4_pkg::W_COS24);

    logic signed [PW-1:0] a_x;
    logic signed [PW-1:0] b_x;

    // rotate the odd pair by the two cosine weights
    always_comb begin
        a_x = PW'(x1);
        b_x = PW'(x3);
        o0  = a_x * K8  + b_x * K24;
        o1  = a_x * K24 - b_x * K8;
    end
endmodule

// File: rtl/idct4_narrow.sv
// Module: rounding narrower. Adds half an LSB, shifts right arithmetically
// by SH and clamps to the signed DW-bit range.
// Assumes: SH >= 1 and DW < PW.
module idct4_narrow #(
    parameter int PW = idct4_pkg::PROD_W,
    parameter int DW = idct4_pkg::COEF_W,
    parameter int SH = idct4_pkg::FRAC_W
) (
    input  logic signed [PW-1:0] v,
    output logic signed [DW-1:0] q
);
    localparam int XW = PW + 1;
    localparam logic signed [XW-1:0] HALF = XW'(1) <<< (SH - 1);
    localparam logic signed [XW-1:0] QMAX = XW'((1 << (DW - 1)) - 1);
    localparam logic signed [XW-1:0] QMIN = -(XW'(1) <<< (DW - 1));

    logic signed [XW-1:0] biased;
    logic signed [XW-1:0] shifted;

    // round, shift and clamp in one step
    always_comb begin
        biased  = XW'(v) + HALF;
        shifted = biased >>> SH;
        if (shifted > QMAX)      q = QMAX[DW-1:0];
        else if (shifted < QMIN) q = QMIN[DW-1:0];
        else                     q = shifted[DW-1:0];
    end

    // sign of the term is kept by the narrowing (R3)
    always_comb begin
        if (!v[PW-1]) p_sign_pos_r3: assert (!q[DW-1]);
        else          p_sign_neg_r3: assert (q[DW-1] || q == '0);
    end
endmodule

// File: rtl/idct4_stage.sv
// Module: one-dimensional 4-point inverse DCT stage (top).
// Even butterfly and odd rotation feed four rounding narrowers; the
// recombination wraps. REGISTERED=1 adds one register stage.
// Assumes: synchronous active-low reset; inputs valid when in_vld is high.
module idct4_stage #(
    parameter int DW         = idct4_pkg::COEF_W,
    parameter int PW         = idct4_pkg::PROD_W,
    parameter int SH         = idct4_pkg::FRAC_W,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_c0,
    input  logic signed [DW-1:0] in_c1,
    input  logic signed [DW-1:0] in_c2,
    input  logic signed [DW-1:0] in_c3,
    output logic                 out_vld,
    output logic signed [DW-1:0] out_y0,
    output logic signed [DW-1:0] out_y1,
    output logic signed [DW-1:0] out_y2,
    output logic signed [DW-1:0] out_y3
);
    localparam int NTERM = 4;

    logic signed [PW-1:0] wide [NTERM];  // e0, e1, o0, o1
    logic signed [DW-1:0] nar  [NTERM];
    logic signed [DW-1:0] y0_c, y1_c, y2_c, y3_c;

    idct4_even #(.DW(DW), .PW(PW)) u_even (
        .x0(in_c0), .x2(in_c2), .e0(wide[0]), .e1(wide[1])
    );

    idct4_odd #(.DW(DW), .PW(PW)) u_odd (
        .x1(in_c1), .x3(in_c3), .o0(wide[2]), .o1(wide[3])
    );

    for (genvar t = 0; t < NTERM; t++) begin : g_narrow
        idct4_narrow #(.PW(PW), .DW(DW), .SH(SH)) u_nar (
            .v(wide[t]), .q(nar[t])
        );
    end

    // wrapping recombination in the fixed output order
    always_comb begin
        y0_c = nar[0] + nar[2];
        y1_c = nar[1] + nar[3];
        y2_c = nar[1] - nar[3];
        y3_c = nar[0] - nar[2];
    end

    if (REGISTERED) begin : g_reg
        // capture results on valid input; valid flag follows by one cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_vld <= 1'b0;
                out_y0  <= '0;
                out_y1  <= '0;
                out_y2  <= '0;
                out_y3  <= '0;
            end else begin
                out_vld <= in_vld;
                if (in_vld) begin
                    out_y0 <= y0_c;
                    out_y1 <= y1_c;
                    out_y2 <= y2_c;
                    out_y3 <= y3_c;
                end
            end
        end

        p_vld_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> out_vld == $past(in_vld));

        p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> ($stable(out_y0) && $stable(out_y1)
                         && $stable(out_y2) && $stable(out_y3)));

        p_even_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_c1 == '0 && in_c3 == '0)
                |=> (out_y0 == out_y3 && out_y1 == out_y2));

        p_c2_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_c2 == '0)
                |=> (DW'(out_y0 + out_y3) == DW'(out_y1 + out_y2)));
    end else begin : g_comb
        // combinational variant: results follow the inputs directly
        always_comb begin
            out_vld = in_vld;
            out_y0  = y0_c;
            out_y1  = y1_c;
            out_y2  = y2_c;
            out_y3  = y3_c;
        end
    end
endmodule

// File: tb/idct4_stage_tb_top.sv
// Bench: stimulus table walked by one loop, random vectors, then directed
// reset, hold, latency and extreme-value cases against an integer model.
module idct4_stage_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam logic [63:0] STIM [NVEC] = '{
        64'h0000_0000_0000_0000,
        64'h0040_0000_0000_0000,
        64'h0000_0040_0000_0000,
        64'h0000_0000_0040_0000,
        64'h0000_0000_0000_0040,
        64'h7FFF_7FFF_7FFF_7FFF,
        64'h8000_8000_8000_8000,
        64'h7FFF_8000_7FFF_8000,
        64'h8000_7FFF_8000_7FFF,
        64'h1234_F00D_0ABC_8001,
        64'hFFFF_0001_FFFF_0001,
        64'h2000_E000_2000_E000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [15:0] c0 = '0, c1 = '0, c2 = '0, c3 = '0;
    logic out_vld;
    logic signed [15:0] y0, y1, y2, y3;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idct4_stage dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .in_c0(c0), .in_c1(c1), .in_c2(c2), .in_c3(c3),
        .out_vld(out_vld),
        .out_y0(y0), .out_y1(y1), .out_y2(y2), .out_y3(y3)
    );

    function automatic longint rnd14(input longint t);
        longint r;
        r = (t + 64'sd8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // independent integer model; returns {y0,y1,y2,y3}
    function automatic logic [63:0] model(input logic [63:0] x);
        shortint a0, a1, a2, a3, s, d;
        longint e0, e1, o0, o1;
        shortint r0, r1, r2, r3;
        a0 = shortint'(x[63:48]); a1 = shortint'(x[47:32]);
        a2 = shortint'(x[31:16]); a3 = shortint'(x[15:0]);
        s  = shortint'(int'(a0) + int'(a2));
        d  = shortint'(int'(a0) - int'(a2));
        e0 = rnd14(longint'(s) * 11585);
        e1 = rnd14(longint'(d) * 11585);
        o0 = rnd14(longint'(a1) * 15137 + longint'(a3) * 6270);
        o1 = rnd14(longint'(a1) * 6270 - longint'(a3) * 15137);
        r0 = shortint'(e0 + o0);
        r1 = shortint'(e1 + o1);
        r2 = shortint'(e1 - o1);
        r3 = shortint'(e0 - o0);
        return {r0, r1, r2, r3};
    endfunction

    task automatic check(input string req, input logic [63:0] got,
                         input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // drive one vector, sample after the capturing edge
    task automatic run_vec(input string req, input logic [63:0] x,
                           input logic [63:0] exp);
        @(negedge clk);
        {c0, c1, c2, c3} = x;
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check({req, " data"}, {y0, y1, y2, y3}, exp);
        check("R7 valid", {63'd0, out_vld}, 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] x;
        // R9: reset clears state
        repeat (3) @(negedge clk);
        check("R9 reset", {out_vld, 63'd0}, 64'd0);
        check("R9 reset data", {y0, y1, y2, y3}, 64'd0);
        rst_n = 1'b1;

        // table walk, R1 R2 R5 against the model
        for (int i = 0; i < NVEC; i++) run_vec("R1 R2 R5 table", STIM[i], model(STIM[i]));

        // R3: DC 64 -> 741440 rounds to 45 in every sample
        run_vec("R3 round", 64'h0040_0000_0000_0000, {4{16'sd45}});

        // R4: c1=c3=32767 saturates odd term to 32767; o1 reduces to -17733
        run_vec("R4 saturate", 64'h0000_7FFF_0000_7FFF,
                {16'sd32767, -16'sd17733, 16'sd17733, -16'sd32767});

        // R1: c0=c2=32767 wraps the sum to -2 -> e0 reduces to -1
        run_vec("R1 wrap", 64'h7FFF_0000_7FFF_0000,
                {-16'sd1, 16'sd0, 16'sd0, -16'sd1});

        // R6: recombination wraps: 23169+32767 -> -9600, 23169+17733 -> -24634
        run_vec("R6 wrap", 64'h7FFF_7FFF_0000_7FFF,
                {-16'sd9600, 16'sd5436, -16'sd24634, -16'sd9598});

        // random vectors
        for (int i = 0; i < 300; i++) begin
            x = {$urandom(), $urandom()};
            run_vec("R2 random", x, model(x));
        end

        // R8: idle input changes nothing; R7: valid low one cycle later
        x = 64'h0100_0200_0300_0400;
        run_vec("R5 setup", x, model(x));
        @(negedge clk);
        {c0, c1, c2, c3} = 64'h7FFF_8000_1111_2222;
        @(negedge clk);
        check("R8 hold", {y0, y1, y2, y3}, model(x));
        check("R7 valid low", {63'd0, out_vld}, 64'd0);

        // R9: reset mid-run
        x = 64'h0500_0600_0700_0800;
        @(negedge clk);
        {c0, c1, c2, c3} = x;
        in_vld = 1'b1;
        rst_n  = 1'b0;
        @(negedge clk);
        check("R9 midrun", {out_vld, 63'd0}, 64'd0);
        check("R9 midrun data", {y0, y1, y2, y3}, 64'd0);
        rst_n  = 1'b1;
        in_vld = 1'b0;
        @(negedge clk);
        check("R7 after reset", {63'd0, out_vld}, 64'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule